// File: doc/BRIEF.md
# Code Lookup RAM Host Access Sequencer

This block steps the control lines around twelve lookup RAMs during host bus accesses. The RAMs form four quadrants. Each quadrant has one track-code RAM and two wedge-code RAMs, and the second wedge RAM of each quadrant also drives summation bits onward. A 12-bit select word, captured at the start of a transaction, picks the RAMs that take part. For every selected RAM, the block drives a write strobe and the buffer direction enables. For track-code RAMs it also drives the latch and path controls of the track-code buffers.

Four kinds of transaction exist: a RAM read, a RAM write, a read of a quadrant's track-code register, and a write of a quadrant's simulated track-code register. Every transaction lasts a fixed number of clocks. A one-cycle done pulse follows. The summation RAMs' output enables follow the operating mode: run or simulation, or configuration.

Top module: `cram_seq`

## Requirements
- R1: Select bit q (q = 0..3) selects the track-code RAM of quadrant q. Bit 4+q selects the first wedge RAM of quadrant q. Bit 8+q selects the second wedge RAM (the summation RAM) of quadrant q. Write-strobe bit k belongs to the RAM of select bit k. Wedge buffer bit j belongs to select bit 4+j.
- R2: When several select bits are set, each selected RAM gets its strobes in the same cycles.
- R3: Operation code 00 is a RAM read, 01 a RAM write, 10 a track-code register read and 11 a track-code register write. The block is idle when it starts a transaction, and it starts one only when `req` is high. A RAM operation also needs `acc_n` low. A request made while a transaction is running is ignored.
- R4: A transaction is active for exactly 4 clocks after the edge that accepts it. `done` is then high for exactly the next one clock.
- R5: `we_n` idles high. Each selected RAM's bit goes low for exactly one clock, in the second active cycle of a RAM write.
- R6: `h2r_en_n` idles high and is low for every active cycle of a RAM write to a selected wedge RAM. `r2h_en` idles low and is high for every active cycle of a RAM read of a selected wedge RAM.
- R7: `tc_le` idles low and is high for every active cycle of a read of the selected track-code RAM. `tc_wen_n` idles high and is low for every active cycle of a write to it.
- R8: `tc2h_en[q]` idles low. It is high for every active cycle of a read of track-code RAM q, and of a register read with `qsel` = q.
- R9: A register write with `qsel` = q drives `tc_clk[q]` high for exactly one clock, the second active cycle. The line idles low.
- R10: `sum_oe_n` is all low when `mode[1]` is 0 (00 run, 01 simulation). When `mode[1]` is 1 (configuration), bit q is low only during a RAM read with select bit 8+q set.
- R11: If `acc_n` is high at a clock edge during an active RAM operation, the block returns to idle after that edge with no `done`. Register operations ignore `acc_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_n | input | 1 | Code-RAM access strobe from the host interface, active low |
| req | input | 1 | Start request |
| op | input | 2 | Operation code (R3) |
| sel | input | 12 | RAM select word (R1) |
| qsel | input | 2 | Quadrant for register operations |
| mode | input | 2 | Operating mode |
| we_n | output | 12 | RAM write strobes, active low |
| h2r_en_n | output | 8 | Host-to-wedge-RAM buffer enables, active low |
| r2h_en | output | 8 | Wedge-RAM-to-host buffer enables |
| tc_le | output | 4 | Track-code buffer latch-enable control |
| tc_wen_n | output | 4 | Track-code-to-RAM buffer enables, active low |
| tc2h_en | output | 4 | Track-code-to-host buffer enables |
| tc_clk | output | 4 | Simulated track-code register clocks |
| sum_oe_n | output | 4 | Summation RAM output enables, active low |
| done | output | 1 | One-cycle transaction-complete pulse |

## Verification
The assertions assume that `mode` stays stable for the length of a transaction. They also assume that the host holds `acc_n` low for the whole of a RAM operation, except when an abort is intended. The stimulus changes inputs only on falling edges. It changes `mode` only between transactions, and it releases `acc_n` in the middle of a transaction only in the abort test. Requests made while a transaction is active are sent on purpose, to show that they are ignored.

// File: rtl/cram_seq_pkg.sv
package cram_seq_pkg;

    typedef enum logic [1:0] {
        OP_RAM_RD = 2'b00,
        OP_RAM_WR = 2'b01,
        OP_REG_RD = 2'b10,
        OP_REG_WR = 2'b11
    } op_e;

    // configuration mode is flagged by the upper mode bit
    localparam int MODE_CFG_BIT = 1;

    function automatic logic is_ram_op(op_e o);
        return (o == OP_RAM_RD) || (o == OP_RAM_WR);
    endfunction

endpackage

// File: rtl/cram_seq_ctrl.sv
module cram_seq_ctrl
    import cram_seq_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int CYC_LEN = 4,
    localparam int NRAM   = 3 * NQ,
    localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CW     = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_n,
    input  logic            req,
    input  op_e             op,
    input  logic [NRAM-1:0] sel,
    input  logic [QW-1:0]   qsel,
    output logic            busy,
    output op_e             op_q,
    output logic [NRAM-1:0] sel_q,
    output logic [QW-1:0]   qsel_q,
    output logic [CW-1:0]   phase,
    output logic            done
);

    localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);

    typedef struct packed {
        logic            busy;
        op_e             op;
        logic [NRAM-1:0] sel;
        logic [QW-1:0]   qsel;
        logic [CW-1:0]   ph;
        logic            done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req && (!is_ram_op(op) || !acc_n)) begin
                st_d.busy = 1'b1;
                st_d.op   = op;
                st_d.sel  = sel;
                st_d.qsel = qsel;
                st_d.ph   = '0;
            end
        end else if (is_ram_op(st_q.op) && acc_n) begin
            st_d.busy = 1'b0;
        end else if (st_q.ph == LAST) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign op_q   = st_q.op;
    assign sel_q  = st_q.sel;
    assign qsel_q = st_q.qsel;
    assign phase  = st_q.ph;
    assign done   = st_q.done;

    // R11: a RAM operation whose strobe is released ends without done
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_ram_op(op_q) && acc_n) |=> (!busy && !done));

    // R4: done lasts one clock and is never raised while active
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);

    // R3: captured operands do not change while active
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(sel_q) && $stable(qsel_q) && $stable(op_q)));

endmodule

// File: rtl/cram_strobe_dec.sv
module cram_strobe_dec
    import cram_seq_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int WE_PHASE = 1,
    parameter int CW       = 2,
    localparam int NRAM    = 3 * NQ,
    localparam int NWDG    = 2 * NQ,
    localparam int QW      = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  op_e             op_q,
    input  logic [NRAM-1:0] sel_q,
    input  logic [QW-1:0]   qsel_q,
    input  logic [CW-1:0]   phase,
    output logic [NRAM-1:0] we_n,
    output logic [NWDG-1:0] h2r_en_n,
    output logic [NWDG-1:0] r2h_en,
    output logic [NQ-1:0]   tc_le,
    output logic [NQ-1:0]   tc_wen_n,
    output logic [NQ-1:0]   tc2h_en,
    output logic [NQ-1:0]   tc_clk,
    output logic            ram_rd
);

    logic ram_wr, reg_rd, reg_wr, pulse_ph;

    always_comb begin
        ram_rd   = busy && (op_q == OP_RAM_RD);
        ram_wr   = busy && (op_q == OP_RAM_WR);
        reg_rd   = busy && (op_q == OP_REG_RD);
        reg_wr   = busy && (op_q == OP_REG_WR);
        pulse_ph = (phase == CW'(WE_PHASE));
    end

    for (genvar k = 0; k < NRAM; k++) begin : g_we
        assign we_n[k] = !(ram_wr && pulse_ph && sel_q[k]);
    end

    for (genvar j = 0; j < NWDG; j++) begin : g_wdg
        assign h2r_en_n[j] = !(ram_wr && sel_q[NQ+j]);
        assign r2h_en[j]   = ram_rd && sel_q[NQ+j];
    end

    for (genvar q = 0; q < NQ; q++) begin : g_trk
        logic hit_q;
        assign hit_q       = (qsel_q == QW'(q));
        assign tc_le[q]    = ram_rd && sel_q[q];
        assign tc_wen_n[q] = !(ram_wr && sel_q[q]);
        assign tc2h_en[q]  = (ram_rd && sel_q[q]) || (reg_rd && hit_q);
        assign tc_clk[q]   = reg_wr && hit_q && pulse_ph;
    end

    // R5: every write strobe returns high one clock after going low
    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n != '1) |=> (we_n == '1));

    // R9: register clock is a single-cycle pulse
    p_tclk_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clk != '0) |=> (tc_clk == '0));

    // R6: a wedge buffer never drives both directions at once
    p_dir_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r2h_en != '0) |-> (h2r_en_n == '1));

    // R7: track-code buffer latch open only when no RAM write path is on
    p_trk_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_le != '0) |-> (tc_wen_n == '1 && we_n == '1));

    // R9: at most one quadrant clock at a time
    p_tclk_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_clk));

endmodule

// File: rtl/cram_sum_oe.sv
module cram_sum_oe
    import cram_seq_pkg::*;
#(
    parameter int NQ    = 4,
    localparam int NRAM = 3 * NQ
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            ram_rd,
    input  logic [NRAM-1:0] sel_q,
    output logic [NQ-1:0]   sum_oe_n
);

    logic cfg;
    assign cfg = mode[MODE_CFG_BIT];

    for (genvar q = 0; q < NQ; q++) begin : g_oe
        assign sum_oe_n[q] = cfg && !(ram_rd && sel_q[2*NQ+q]);
    end

    // R10: outside configuration every summation RAM drives
    p_run_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg |-> (sum_oe_n == '0));

    // R10: in configuration with no read active all are held off
    p_cfg_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg && !ram_rd) |-> (sum_oe_n == '1));

endmodule

// File: rtl/cram_seq.sv
module cram_seq
    import cram_seq_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int CYC_LEN  = 4,
    parameter int WE_PHASE = 1,
    localparam int NRAM    = 3 * NQ,
    localparam int NWDG    = 2 * NQ,
    localparam int QW      = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CW      = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_n,
    input  logic            req,
    input  logic [1:0]      op,
    input  logic [NRAM-1:0] sel,
    input  logic [QW-1:0]   qsel,
    input  logic [1:0]      mode,
    output logic [NRAM-1:0] we_n,
    output logic [NWDG-1:0] h2r_en_n,
    output logic [NWDG-1:0] r2h_en,
    output logic [NQ-1:0]   tc_le,
    output logic [NQ-1:0]   tc_wen_n,
    output logic [NQ-1:0]   tc2h_en,
    output logic [NQ-1:0]   tc_clk,
    output logic [NQ-1:0]   sum_oe_n,
    output logic            done
);

    logic            busy, ram_rd;
    op_e             op_q;
    logic [NRAM-1:0] sel_q;
    logic [QW-1:0]   qsel_q;
    logic [CW-1:0]   phase;

    cram_seq_ctrl #(.NQ(NQ), .CYC_LEN(CYC_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_n(acc_n), .req(req), .op(op_e'(op)),
        .sel(sel), .qsel(qsel), .busy(busy), .op_q(op_q), .sel_q(sel_q),
        .qsel_q(qsel_q), .phase(phase), .done(done)
    );

    cram_strobe_dec #(.NQ(NQ), .WE_PHASE(WE_PHASE), .CW(CW)) u_dec (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_q(op_q), .sel_q(sel_q),
        .qsel_q(qsel_q), .phase(phase), .we_n(we_n), .h2r_en_n(h2r_en_n),
        .r2h_en(r2h_en), .tc_le(tc_le), .tc_wen_n(tc_wen_n),
        .tc2h_en(tc2h_en), .tc_clk(tc_clk), .ram_rd(ram_rd)
    );

    cram_sum_oe #(.NQ(NQ)) u_oe (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ram_rd(ram_rd),
        .sel_q(sel_q), .sum_oe_n(sum_oe_n)
    );

    // R2: all selected RAMs strobe together; none outside the selection
    p_we_in_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n != '1) |-> ((~we_n & ~sel_q) == '0 && (~we_n) == sel_q));

endmodule

// File: tb/cram_seq_tb.sv
module cram_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_n = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [11:0] sel = '0;
    logic [1:0]  qsel = '0;
    logic [1:0]  mode = 2'b00;
    logic [11:0] we_n;
    logic [7:0]  h2r_en_n, r2h_en;
    logic [3:0]  tc_le, tc_wen_n, tc2h_en, tc_clk, sum_oe_n;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    cram_seq u_dut (
        .clk(clk), .rst_n(rst_n), .acc_n(acc_n), .req(req), .op(op),
        .sel(sel), .qsel(qsel), .mode(mode), .we_n(we_n),
        .h2r_en_n(h2r_en_n), .r2h_en(r2h_en), .tc_le(tc_le),
        .tc_wen_n(tc_wen_n), .tc2h_en(tc2h_en), .tc_clk(tc_clk),
        .sum_oe_n(sum_oe_n), .done(done)
    );

    typedef struct packed {
        logic [11:0] we_n;
        logic [7:0]  h2r_n;
        logic [7:0]  r2h;
        logic [3:0]  le;
        logic [3:0]  twn;
        logic [3:0]  t2h;
        logic [3:0]  tclk;
        logic [3:0]  soe;
        logic        dn;
    } exp_t;

    // vector: {op[1:0], sel[11:0], qsel[1:0], mode[1:0]}
    localparam int NV = 9;
    localparam logic [17:0] VEC [NV] = '{
        {2'b00, 12'h001, 2'd0, 2'b00},   // R1: track RAM q0 read, run
        {2'b01, 12'h010, 2'd0, 2'b10},   // R1: wedge A q0 write, config
        {2'b01, 12'hF0F, 2'd0, 2'b01},   // R2: multi-select write, sim
        {2'b00, 12'h400, 2'd0, 2'b10},   // R10: summation q2 read, config
        {2'b00, 12'h400, 2'd0, 2'b00},   // R10: summation q2 read, run
        {2'b10, 12'h000, 2'd3, 2'b00},   // R8: register read q3
        {2'b11, 12'h000, 2'd2, 2'b11},   // R9: register write q2
        {2'b01, 12'h800, 2'd0, 2'b11},   // R10: write to summation RAM, config
        {2'b00, 12'h0A8, 2'd0, 2'b10}    // R1: mixed read track q3 + wedge A q1,q3
    };

    function automatic exp_t model(logic [1:0] o, logic [11:0] s, logic [1:0] qs,
                                   logic [1:0] md, bit act, int ph, bit dn);
        exp_t e;
        bit rd = act && (o == 2'b00);
        bit wr = act && (o == 2'b01);
        e.we_n = '1; e.h2r_n = '1; e.r2h = '0; e.le = '0; e.twn = '1;
        e.t2h = '0; e.tclk = '0; e.soe = '0; e.dn = dn;
        for (int k = 0; k < 12; k++)
            if (wr && s[k] && ph == 1) e.we_n[k] = 1'b0;
        for (int j = 0; j < 8; j++) begin
            e.h2r_n[j] = !(wr && s[4+j]);
            e.r2h[j]   = rd && s[4+j];
        end
        for (int q = 0; q < 4; q++) begin
            e.le[q]   = rd && s[q];
            e.twn[q]  = !(wr && s[q]);
            e.t2h[q]  = (rd && s[q]) || (act && o == 2'b10 && qs == 2'(q));
            e.tclk[q] = act && o == 2'b11 && qs == 2'(q) && ph == 1;
            e.soe[q]  = md[1] ? !(rd && s[8+q]) : 1'b0;
        end
        return e;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all(string ctx, exp_t e);
        chk({ctx, " R5 we_n"},      16'(we_n),     16'(e.we_n));
        chk({ctx, " R6 h2r_en_n"},  16'(h2r_en_n), 16'(e.h2r_n));
        chk({ctx, " R6 r2h_en"},    16'(r2h_en),   16'(e.r2h));
        chk({ctx, " R7 tc_le"},     16'(tc_le),    16'(e.le));
        chk({ctx, " R7 tc_wen_n"},  16'(tc_wen_n), 16'(e.twn));
        chk({ctx, " R8 tc2h_en"},   16'(tc2h_en),  16'(e.t2h));
        chk({ctx, " R9 tc_clk"},    16'(tc_clk),   16'(e.tclk));
        chk({ctx, " R10 sum_oe_n"}, 16'(sum_oe_n), 16'(e.soe));
        chk({ctx, " R4 done"},      16'(done),     16'(e.dn));
    endtask

    // start at a falling edge; accepted at the next rising edge
    task automatic start(logic [1:0] o, logic [11:0] s, logic [1:0] qs,
                         logic [1:0] md, logic a_n);
        op = o; sel = s; qsel = qs; mode = md; acc_n = a_n; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state: all lines idle, run mode
        chk_all("reset", model(2'b00, 12'h000, 2'd0, 2'b00, 0, 0, 0));
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            logic [1:0] o = VEC[v][17:16];
            logic [11:0] s = VEC[v][15:4];
            logic [1:0] qs = VEC[v][3:2];
            logic [1:0] md = VEC[v][1:0];
            start(o, s, qs, md, 1'b0);
            for (int ph = 0; ph < 4; ph++) begin
                chk_all($sformatf("vec%0d ph%0d", v, ph), model(o, s, qs, md, 1, ph, 0));
                @(negedge clk);
            end
            chk_all($sformatf("vec%0d done", v), model(o, s, qs, md, 0, 0, 1));
            acc_n = 1'b1;
            @(negedge clk);
            chk_all($sformatf("vec%0d after", v), model(o, s, qs, md, 0, 0, 0));
        end

        // R3: RAM op with acc_n high is not accepted
        start(2'b00, 12'h0FF, 2'd0, 2'b10, 1'b1);
        for (int i = 0; i < 5; i++) begin
            chk($sformatf("R3 no-start r2h c%0d", i), 16'(r2h_en), 16'h0);
            chk($sformatf("R3 no-start done c%0d", i), 16'(done), 16'h0);
            @(negedge clk);
        end

        // R3: request while busy ignored; first transaction completes normally
        start(2'b00, 12'h010, 2'd0, 2'b10, 1'b0);
        op = 2'b01; sel = 12'hFFF; req = 1'b1;   // during phase 1
        @(negedge clk);
        req = 1'b0;
        chk("R3 busy-ignore we_n ph1", 16'(we_n), 16'hFFF);
        chk("R3 busy-ignore r2h ph1", 16'(r2h_en), 16'h01);
        @(negedge clk);
        chk("R3 busy-ignore we_n ph2", 16'(we_n), 16'hFFF);
        chk("R3 busy-ignore h2r ph2", 16'(h2r_en_n), 16'hFF);
        @(negedge clk);
        @(negedge clk);
        chk("R3 busy-ignore done", 16'(done), 16'h1);
        chk("R3 busy-ignore idle r2h", 16'(r2h_en), 16'h0);
        acc_n = 1'b1;
        @(negedge clk);
        chk("R3 no late start we_n", 16'(we_n), 16'hFFF);

        // R11: abort RAM read by releasing acc_n
        start(2'b00, 12'h101, 2'd0, 2'b10, 1'b0);
        chk("R11 pre-abort tc_le", 16'(tc_le), 16'h1);
        chk("R11 pre-abort sum_oe_n", 16'(sum_oe_n), 16'hE);
        acc_n = 1'b1;
        @(negedge clk);
        chk("R11 abort tc_le", 16'(tc_le), 16'h0);
        chk("R11 abort sum_oe_n", 16'(sum_oe_n), 16'hF);
        chk("R11 abort done", 16'(done), 16'h0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk($sformatf("R11 abort no done c%0d", i), 16'(done), 16'h0);
        end

        // R11: register write ignores acc_n
        start(2'b11, 12'h000, 2'd1, 2'b00, 1'b1);
        chk("R11 reg ph0 tc_clk", 16'(tc_clk), 16'h0);
        @(negedge clk);
        chk("R11 reg ph1 tc_clk", 16'(tc_clk), 16'h2);
        @(negedge clk);
        chk("R11 reg ph2 tc_clk", 16'(tc_clk), 16'h0);
        @(negedge clk);
        @(negedge clk);
        chk("R11 reg done", 16'(done), 16'h1);

        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R4 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule